// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block sets the instruction rhythm of a small 8-bit controller core that reads 16-bit program words. It splits the oscillator into instruction cycles of four phases. It gives one strobe per oscillator period, a pulse that marks the start of each cycle, and a fetch enable on the last phase. Fetch and execute overlap: while one word executes, the next word is read from the address the sequencer holds. At every cycle boundary the fetched word is latched for the execute stage, and the fetch address moves on.

The execute stage reports three events, and the sequencer samples them on the last phase only: a conditional skip that came out true, a write of a new program-counter value, and the decode of a two-word opcode. Any of these flags the word already in flight, so the whole next cycle runs as a NOP. This costs a flush cycle and never a stall. A word whose top four bits are all ones is the tail of a two-word instruction. It always runs as a NOP, so a skip that lands on such a tail does no harm. After reset the first cycle is a NOP, and the word at the reset vector executes in the second cycle.

Top module: `icyc_seq`

## Requirements
- R1: While reset is asserted, and from the moment it is asserted mid-run, the phase-0 strobe is the only strobe high, fetch_addr equals RST_VEC (0), force_nop is 1 and fetch_en is 0. The first cycle after reset release is a NOP.
- R2: ph_strb is one-hot. ph_strb[i] is high in phase i, each phase lasts one clock, and the phases run 0,1,2,3 and then back to 0.
- R3: cyc_start is high exactly in phase 0 and fetch_en is high exactly in phase 3.
- R4: At the end of each cycle with no PC write, fetch_addr advances by one, modulo 2^ADDR_W. During the next cycle, ir_word presents the prog_word value sampled in phase 3.
- R5: A skip_tk sampled high in phase 3 makes force_nop 1 for the whole next cycle. The address still advances by one.
- R6: A pc_wr sampled high in phase 3 loads fetch_addr with pc_new and makes force_nop 1 for the whole next cycle.
- R7: A two_word sampled high in phase 3 makes force_nop 1 for the whole next cycle.
- R8: A word in ir_word whose bits [15:12] are all 1 forces force_nop to 1 for its whole cycle.
- R9: A true skip whose next word is the first word of a two-word instruction gives two NOP cycles after the skip cycle, so the skip costs three cycles. The word after the pair then executes normally.
- R10: skip_tk, pc_wr and two_word have no effect when they are high only in phases 0 to 2.
- R11: force_nop changes only at a cycle boundary and holds for all four phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_word | input | WORD_W | Word read from program memory at fetch_addr |
| skip_tk | input | 1 | Execute stage: conditional skip came out true |
| pc_wr | input | 1 | Execute stage: program counter written |
| pc_new | input | ADDR_W | New program-counter value, used with pc_wr |
| two_word | input | 1 | Execute stage: two-word opcode decoded |
| ph_strb | output | PH_N | One-hot phase strobes |
| cyc_start | output | 1 | High in the first phase of each cycle |
| fetch_en | output | 1 | High in the last phase, when prog_word is latched |
| fetch_addr | output | ADDR_W | Current fetch address |
| ir_word | output | WORD_W | Word presented to the execute stage this cycle |
| force_nop | output | 1 | Execute stage must treat ir_word as a NOP |

## Verification
The bench builds the block with PH_N=4, WORD_W=16 and ADDR_W=8. With an 8-bit address, a PC write to 8'hFF followed by a plain cycle shows the address wrapping to zero within a few cycles. The four-phase setting lets each directed task check every strobe of a cycle one by one. The same tasks check the flush flag, the skip-onto-tail sequence, and flags that drop before the sampling phase.

// File: rtl/icyc_pkg.sv
package icyc_pkg;
  typedef struct packed {
    logic skip;
    logic pc_wr;
    logic two_word;
  } exec_req_t;
endpackage

// File: rtl/icyc_phase_gen.sv
module icyc_phase_gen #(
  parameter int PH_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_N-1:0] ph_strb,
  output logic            first,
  output logic            last
);
  localparam int PH_W = (PH_N > 1) ? $clog2(PH_N) : 1;

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (last) ph_d = '0;
    else      ph_d = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < PH_N; gi++) begin : g_strb
      assign ph_strb[gi] = (ph_q == PH_W'(gi));
    end
  endgenerate

  assign first = ph_strb[0];
  assign last  = ph_strb[PH_N-1];

  // R2: the last phase is followed by the first one
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_strb[PH_N-1] |=> ph_strb[0]);
  // R2: phase 0 is followed by phase 1
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_strb[0] |=> ph_strb[1]);
endmodule

// File: rtl/icyc_fetch_ctl.sv
module icyc_fetch_ctl #(
  parameter int ADDR_W  = 12,
  parameter int WORD_W  = 16,
  parameter int RST_VEC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              pc_wr,
  input  logic [ADDR_W-1:0] pc_new,
  input  logic [WORD_W-1:0] prog_word,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [WORD_W-1:0] ir_word
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [WORD_W-1:0] ir_q, ir_d;

  always_comb begin
    pc_d = pc_q;
    ir_d = ir_q;
    if (adv) begin
      ir_d = prog_word;
      if (pc_wr) pc_d = pc_new;
      else       pc_d = pc_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= ADDR_W'(RST_VEC);
      ir_q <= '0;
    end else begin
      pc_q <= pc_d;
      ir_q <= ir_d;
    end
  end

  assign fetch_addr = pc_q;
  assign ir_word    = ir_q;

  // R4: address steps by one at a boundary without PC write
  assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !pc_wr) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));
  // R6: PC write loads the supplied value
  assert_pc_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && pc_wr) |=> fetch_addr == $past(pc_new));
  // R4: address holds inside a cycle
  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(fetch_addr) && $stable(ir_word));
endmodule

// File: rtl/icyc_flush_ctl.sv
module icyc_flush_ctl
  import icyc_pkg::*;
#(
  parameter int MARK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              first,
  input  exec_req_t         req,
  input  logic [MARK_W-1:0] mark_bits,
  output logic              force_nop
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (adv) flag_d = req.skip | req.pc_wr | req.two_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= flag_d;
  end

  assign force_nop = flag_q | (&mark_bits);

  // R5: true skip flushes the next cycle
  assert_skip_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && req.skip) |=> force_nop);
  // R7: two-word decode flushes the next cycle
  assert_tw_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && req.two_word) |=> force_nop);
  // R11: no change of the flag inside a cycle
  assert_nop_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !first |-> $stable(force_nop));
endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
  import icyc_pkg::*;
#(
  parameter int PH_N    = 4,
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 12,
  parameter int MARK_W  = 4,
  parameter int RST_VEC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] prog_word,
  input  logic              skip_tk,
  input  logic              pc_wr,
  input  logic [ADDR_W-1:0] pc_new,
  input  logic              two_word,
  output logic [PH_N-1:0]   ph_strb,
  output logic              cyc_start,
  output logic              fetch_en,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [WORD_W-1:0] ir_word,
  output logic              force_nop
);
  logic [1:0] rs_q;
  logic       rst_i;
  logic       first, last;
  exec_req_t  req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign req.skip     = skip_tk;
  assign req.pc_wr    = pc_wr;
  assign req.two_word = two_word;

  icyc_phase_gen #(.PH_N(PH_N)) u_phase (
    .clk(clk), .rst_n(rst_i), .ph_strb(ph_strb), .first(first), .last(last)
  );

  icyc_fetch_ctl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RST_VEC(RST_VEC)) u_fetch (
    .clk(clk), .rst_n(rst_i), .adv(last), .pc_wr(pc_wr), .pc_new(pc_new),
    .prog_word(prog_word), .fetch_addr(fetch_addr), .ir_word(ir_word)
  );

  icyc_flush_ctl #(.MARK_W(MARK_W)) u_flush (
    .clk(clk), .rst_n(rst_i), .adv(last), .first(first), .req(req),
    .mark_bits(ir_word[WORD_W-1 -: MARK_W]), .force_nop(force_nop)
  );

  assign cyc_start = first;
  assign fetch_en  = last;

  // R8: a tail-marked word never executes
  assert_marker_nop_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (&ir_word[WORD_W-1 -: MARK_W]) |-> force_nop);
  // R1: first cycle after reset release is a NOP
  assert_reset_nop_R1: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(rst_i) |-> force_nop && cyc_start);
endmodule

// File: tb/test_icyc_seq.sv
module test_icyc_seq;
  localparam int NP = 4, WW = 16, AW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [WW-1:0] prog_word;
  logic          skip_tk, pc_wr, two_word;
  logic [AW-1:0] pc_new;
  logic [NP-1:0] ph_strb;
  logic          cyc_start, fetch_en, force_nop;
  logic [AW-1:0] fetch_addr;
  logic [WW-1:0] ir_word;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] exp_pc;

  icyc_seq #(.PH_N(NP), .WORD_W(WW), .ADDR_W(AW), .MARK_W(4), .RST_VEC(0)) i_icyc_seq (
    .clk(clk), .rst_n(rst_n), .prog_word(prog_word), .skip_tk(skip_tk),
    .pc_wr(pc_wr), .pc_new(pc_new), .two_word(two_word), .ph_strb(ph_strb),
    .cyc_start(cyc_start), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
    .ir_word(ir_word), .force_nop(force_nop)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) act=running exp=done");
    summary();
    $finish;
  end

  task automatic clear_exec();
    skip_tk = 1'b0; pc_wr = 1'b0; two_word = 1'b0; pc_new = '0;
  endtask

  // R1: reset state, release, first cycle a NOP; ends at phase 0 of cycle 1
  task automatic do_reset();
    clear_exec();
    prog_word = 16'h1000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", 32'(ph_strb), 32'h1);
    chk("R1 addr in reset", 32'(fetch_addr), 32'h0);
    chk("R1 nop in reset", 32'(force_nop), 32'h1);
    chk("R1 fetch_en in reset", 32'(fetch_en), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    while (!ph_strb[NP-1]) @(negedge clk);
    chk("R1 first cycle nop", 32'(force_nop), 32'h1);
    chk("R1 first cycle addr", 32'(fetch_addr), 32'h0);
    @(negedge clk);
    exp_pc = 8'h01;
    chk("R4 after first fetch addr", 32'(fetch_addr), 32'(exp_pc));
    chk("R4 after first fetch word", 32'(ir_word), 32'h1000);
    chk("R1 second cycle executes", 32'(force_nop), 32'h0);
  endtask

  // one full cycle from phase 0; word is what memory returns for fetch_addr
  task automatic cyc(input logic [WW-1:0] word, input logic sk, input logic pw,
                     input logic [AW-1:0] npc, input logic tw, input string tag);
    logic nop0;
    logic exp_nop;
    prog_word = word; skip_tk = sk; pc_wr = pw; pc_new = npc; two_word = tw;
    nop0 = force_nop;
    for (int p = 0; p < NP; p++) begin
      chk("R2 strobe", 32'(ph_strb), 32'(1 << p));
      chk("R3 cyc_start", 32'(cyc_start), 32'(p == 0));
      chk("R3 fetch_en", 32'(fetch_en), 32'(p == NP - 1));
      chk("R11 nop steady", 32'(force_nop), 32'(nop0));
      @(negedge clk);
    end
    clear_exec();
    exp_pc  = pw ? npc : exp_pc + 8'h01;
    exp_nop = sk | pw | tw | (&word[15:12]);
    chk({tag, " addr"}, 32'(fetch_addr), 32'(exp_pc));
    chk({tag, " word"}, 32'(ir_word), 32'(word));
    chk({tag, " nop"}, 32'(force_nop), 32'(exp_nop));
  endtask

  task automatic t_plain();
    cyc(16'h0A11, 0, 0, 8'h00, 0, "R4 plain a");
    cyc(16'h0A22, 0, 0, 8'h00, 0, "R4 plain b");
    cyc(16'h7A33, 0, 0, 8'h00, 0, "R4 plain c");
  endtask

  task automatic t_skip();
    cyc(16'h2222, 1, 0, 8'h00, 0, "R5 skip");
    cyc(16'h3333, 0, 0, 8'h00, 0, "R5 after skip");
  endtask

  task automatic t_pcwr();
    cyc(16'h4444, 0, 1, 8'hF0, 0, "R6 load");
    cyc(16'h4445, 0, 0, 8'h00, 0, "R6 after load");
    cyc(16'h4446, 0, 1, 8'hFF, 0, "R6 load top");
    cyc(16'h4447, 0, 0, 8'h00, 0, "R4 wrap");
  endtask

  task automatic t_two_word();
    cyc(16'h5555, 0, 0, 8'h00, 1, "R7 two-word");
    cyc(16'h5556, 0, 0, 8'h00, 0, "R7 after");
  endtask

  task automatic t_marker();
    cyc(16'hF123, 0, 0, 8'h00, 0, "R8 tail alone");
    cyc(16'hE123, 0, 0, 8'h00, 0, "R8 non-tail");
  endtask

  task automatic t_skip_tail();
    cyc(16'hC001, 1, 0, 8'h00, 0, "R9 skip onto pair");
    cyc(16'hF0AB, 0, 0, 8'h00, 0, "R9 tail cycle");
    cyc(16'h0777, 0, 0, 8'h00, 0, "R9 resume");
  endtask

  task automatic t_ignore();
    prog_word = 16'h0888;
    skip_tk = 1'b1; pc_wr = 1'b1; two_word = 1'b1; pc_new = 8'hAA;
    repeat (NP - 1) @(negedge clk);
    clear_exec();
    @(negedge clk);
    exp_pc = exp_pc + 8'h01;
    chk("R10 addr unaffected", 32'(fetch_addr), 32'(exp_pc));
    chk("R10 no flush", 32'(force_nop), 32'h0);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async strobe", 32'(ph_strb), 32'h1);
    chk("R1 async addr", 32'(fetch_addr), 32'h0);
    chk("R1 async nop", 32'(force_nop), 32'h1);
    do_reset();
  endtask

  initial begin
    rst_n = 1'b0;
    prog_word = '0;
    clear_exec();
    exp_pc = '0;
    do_reset();
    t_plain();
    t_skip();
    t_pcwr();
    t_two_word();
    t_marker();
    t_skip_tail();
    t_ignore();
    t_mid_reset();
    t_plain();
    summary();
    $finish;
  end
endmodule